// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a pipelined synchronous static RAM with a built-in 4-word burst sequencer. A word is 36 bits wide and is split into four 9-bit lanes, each holding 8 data bits and 1 parity bit. All address and control inputs are captured on the rising clock edge. Two address strobes can open a burst. One is meant for a processor and one for a cache controller. After a strobe, an advance input steps a 2-bit counter over the low two address bits. The upper address bits stay fixed, so a burst always wraps inside its aligned 4-word block.

A static order input picks the burst sequence. The sequence is either a wrapping linear count or the interleaved order, in which each step is XORed onto the starting offset. A global write strobe writes the whole word. A byte-write strobe together with per-lane strobes writes only the chosen lanes. Three chip-enable inputs gate the strobes. Read data is registered and appears one clock after the access. Its valid flag is masked without a clock by an output-enable input and by a power-down input. While power-down is high, every access and all burst state are frozen.

Top module: `sync_burst_sram`

## Requirements
- R1: After a synchronous reset, `dout_vld_o` is low and no burst is active, so advance cycles without a strobe produce no read data.
- R2: A read access captured at clock edge k drives its word on `dout_o`, with `dout_vld_o` high, from just after edge k+1 until edge k+2.
- R3: With `order_i` = 0 (linear), burst step n (n = 0..3) accesses the address whose low two bits are (start + n) mod 4, while the upper bits stay those of the start address.
- R4: With `order_i` = 1 (interleaved), burst step n accesses the address whose low two bits are start XOR n, while the upper bits are unchanged.
- R5: In a cycle inside a burst with `adv_n_i` high and no strobe, the counter holds and the same address is accessed again.
- R6: `gw_n_i` low writes all four lanes, whatever `bwe_n_i` and `bw_n_i` say. Lane i is bits [9i+8:9i] of the word.
- R7: With `gw_n_i` high and `bwe_n_i` low, exactly the lanes i with `bw_n_i[i]` = 0 are written. If every `bw_n_i` bit is high, or `bwe_n_i` is high, the access is a read.
- R8: `adsp_n_i` low is ignored while `cs1_n_i` is high. A burst in progress then carries on as if no strobe were present.
- R9: When both strobes are low and `cs1_n_i` is low, the processor strobe wins. That access is always a read, and write strobes are honoured on the cycles that follow.
- R10: The device is selected only when `cs1_n_i`=0, `cs2_i`=1 and `cs2_n_i`=0. An effective strobe while deselected ends the burst, and later advance cycles return no data.
- R11: `oe_n_i` high forces `dout_vld_o` low combinationally, within the same clock cycle.
- R12: While `zz_i` is high, `dout_vld_o` is low, no write changes the array, and the burst position is held. When `zz_i` falls, the burst resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address sampled by a strobe |
| din_i | input | 36 | Write data, four 9-bit lanes |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| cs1_n_i | input | 1 | Chip enable, active low; also gates the processor strobe |
| cs2_i | input | 1 | Chip enable, active high |
| cs2_n_i | input | 1 | Chip enable, active low |
| gw_n_i | input | 1 | Global write of all lanes, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bw_n_i | input | 4 | Per-lane write strobes, active low, bit i = lane i |
| oe_n_i | input | 1 | Output enable, active low, acts without a clock |
| zz_i | input | 1 | Power-down, active high |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| dout_o | output | 36 | Registered read data |
| dout_vld_o | output | 1 | Read data valid and driven |

## Verification
A counter or base register that holds a wrong value shows at the ports as the wrong word. That word appears on the very next read, one clock after the bad access. Each burst step is therefore compared with a reference computed for that step alone. A lane-mask or strobe-priority fault shows up as stale or corrupted lanes at the next read-back of the same address. So every write pattern is read back at once. A chip-select or power-down fault shows as read data that should not exist, or as a burst that resumes at the wrong offset. Both are visible within two clocks.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 9;
    localparam int WORD_W  = LANES * LANE_W;
    localparam int BURST_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [2:0] {
        CMD_IDLE    = 3'd0,
        CMD_DESEL   = 3'd1,
        CMD_START_P = 3'd2,
        CMD_START_C = 3'd3,
        CMD_CONT    = 3'd4
    } cmd_e;

    typedef struct packed {
        cmd_e             cmd;
        logic             adv;
        logic             wr;
        logic [LANES-1:0] mask;
    } req_t;

    // low address bits for a given burst step
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] step,
        input order_e             ord
    );
        if (ord == ORD_INTERLEAVE)
            return base ^ step;
        else
            return base + step;
    endfunction

endpackage

// File: rtl/sbs_cmd_decode.sv
`timescale 1ns/1ps
module sbs_cmd_decode
    import sbs_pkg::*;
(
    input  logic             zz_i,
    input  logic             active_i,
    input  logic             adsp_n_i,
    input  logic             adsc_n_i,
    input  logic             adv_n_i,
    input  logic             cs1_n_i,
    input  logic             cs2_i,
    input  logic             cs2_n_i,
    input  logic             gw_n_i,
    input  logic             bwe_n_i,
    input  logic [LANES-1:0] bw_n_i,
    output req_t             req_o
);

    logic             selected;
    logic             p_strobe;
    logic [LANES-1:0] lane_mask;

    always_comb begin
        selected = !cs1_n_i && cs2_i && !cs2_n_i;
        // processor strobe is blocked by the first chip enable
        p_strobe = !adsp_n_i && !cs1_n_i;

        if (!gw_n_i)
            lane_mask = '1;
        else if (!bwe_n_i)
            lane_mask = ~bw_n_i;
        else
            lane_mask = '0;

        req_o.cmd  = CMD_IDLE;
        req_o.adv  = !adv_n_i;
        req_o.wr   = 1'b0;
        req_o.mask = lane_mask;

        if (zz_i) begin
            req_o.cmd = CMD_IDLE;
        end else if (p_strobe) begin
            req_o.cmd = selected ? CMD_START_P : CMD_DESEL;
        end else if (!adsc_n_i) begin
            req_o.cmd = selected ? CMD_START_C : CMD_DESEL;
            req_o.wr  = selected && (lane_mask != '0);
        end else if (active_i) begin
            req_o.cmd = CMD_CONT;
            req_o.wr  = (lane_mask != '0);
        end
    end

endmodule

// File: rtl/sbs_burst_ctr.sv
`timescale 1ns/1ps
module sbs_burst_ctr
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  req_t               req_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  order_e             order_i,
    output logic               active_o,
    output logic [BURST_W-1:0] cnt_o,
    output logic               acc_en_o,
    output logic               acc_wr_o,
    output logic [LANES-1:0]   acc_mask_o,
    output logic [ADDR_W-1:0]  acc_addr_o
);

    localparam int UP_W = ADDR_W - BURST_W;

    logic [UP_W-1:0]    up_q;
    logic [BURST_W-1:0] base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               active_q;
    logic [BURST_W-1:0] step;

    always_comb begin
        step       = cnt_q;
        acc_en_o   = 1'b0;
        acc_wr_o   = 1'b0;
        acc_mask_o = req_i.mask;
        acc_addr_o = {up_q, burst_low(base_q, cnt_q, order_i)};
        unique case (req_i.cmd)
            CMD_START_P: begin
                acc_en_o   = 1'b1;
                acc_addr_o = addr_i;
            end
            CMD_START_C: begin
                acc_en_o   = 1'b1;
                acc_wr_o   = req_i.wr;
                acc_addr_o = addr_i;
            end
            CMD_CONT: begin
                step       = req_i.adv ? cnt_q + 2'd1 : cnt_q;
                acc_en_o   = 1'b1;
                acc_wr_o   = req_i.wr;
                acc_addr_o = {up_q, burst_low(base_q, step, order_i)};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            up_q     <= '0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else begin
            unique case (req_i.cmd)
                CMD_START_P, CMD_START_C: begin
                    active_q <= 1'b1;
                    up_q     <= addr_i[ADDR_W-1:BURST_W];
                    base_q   <= addr_i[BURST_W-1:0];
                    cnt_q    <= '0;
                end
                CMD_CONT:  cnt_q    <= step;
                CMD_DESEL: active_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign active_o = active_q;
    assign cnt_o    = cnt_q;

endmodule

// File: rtl/sbs_lane_array.sv
`timescale 1ns/1ps
module sbs_lane_array
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              zz_i,
    input  logic              acc_en_i,
    input  logic              acc_wr_i,
    input  logic [LANES-1:0]  acc_mask_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rd_vld_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic              rd_pend_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend_q <= 1'b0;
            rd_addr_q <= '0;
            vld_q     <= 1'b0;
        end else if (zz_i) begin
            rd_pend_q <= 1'b0;
            vld_q     <= 1'b0;
        end else begin
            rd_pend_q <= acc_en_i && !acc_wr_i;
            if (acc_en_i)
                rd_addr_q <= acc_addr_i;
            vld_q <= rd_pend_q;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] dq;

        always_ff @(posedge clk) begin
            if (!zz_i && acc_en_i && acc_wr_i && acc_mask_i[g])
                mem[acc_addr_i] <= wr_data_i[g*LANE_W +: LANE_W];
            if (!zz_i && rd_pend_q)
                dq <= mem[rd_addr_q];
        end

        assign rd_data_o[g*LANE_W +: LANE_W] = dq;
    end

    assign rd_vld_o = vld_q;

endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic              adsp_n_i,
    input  logic              adsc_n_i,
    input  logic              adv_n_i,
    input  logic              cs1_n_i,
    input  logic              cs2_i,
    input  logic              cs2_n_i,
    input  logic              gw_n_i,
    input  logic              bwe_n_i,
    input  logic [LANES-1:0]  bw_n_i,
    input  logic              oe_n_i,
    input  logic              zz_i,
    input  logic              order_i,
    output logic [WORD_W-1:0] dout_o,
    output logic              dout_vld_o
);

    req_t               req;
    logic               burst_active;
    logic [BURST_W-1:0] burst_cnt;
    logic               acc_en;
    logic               acc_wr;
    logic [LANES-1:0]   acc_mask;
    logic [ADDR_W-1:0]  acc_addr;
    logic               rd_vld;

    sbs_cmd_decode i_dec (
        .zz_i     (zz_i),
        .active_i (burst_active),
        .adsp_n_i (adsp_n_i),
        .adsc_n_i (adsc_n_i),
        .adv_n_i  (adv_n_i),
        .cs1_n_i  (cs1_n_i),
        .cs2_i    (cs2_i),
        .cs2_n_i  (cs2_n_i),
        .gw_n_i   (gw_n_i),
        .bwe_n_i  (bwe_n_i),
        .bw_n_i   (bw_n_i),
        .req_o    (req)
    );

    sbs_burst_ctr #(.ADDR_W(ADDR_W)) i_ctr (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .addr_i     (addr_i),
        .order_i    (order_e'(order_i)),
        .active_o   (burst_active),
        .cnt_o      (burst_cnt),
        .acc_en_o   (acc_en),
        .acc_wr_o   (acc_wr),
        .acc_mask_o (acc_mask),
        .acc_addr_o (acc_addr)
    );

    sbs_lane_array #(.ADDR_W(ADDR_W)) i_arr (
        .clk        (clk),
        .rst        (rst),
        .zz_i       (zz_i),
        .acc_en_i   (acc_en),
        .acc_wr_i   (acc_wr),
        .acc_mask_i (acc_mask),
        .acc_addr_i (acc_addr),
        .wr_data_i  (din_i),
        .rd_data_o  (dout_o),
        .rd_vld_o   (rd_vld)
    );

    // output gating needs no clock
    assign dout_vld_o = rd_vld && !oe_n_i && !zz_i;

endmodule

// File: rtl/sbs_checker.sv
`timescale 1ns/1ps
module sbs_checker (
    input logic       clk,
    input logic       rst,
    input logic       zz_i,
    input logic       oe_n_i,
    input logic       adsp_n_i,
    input logic       adsc_n_i,
    input logic       adv_n_i,
    input logic       cs1_n_i,
    input logic       cs2_i,
    input logic       cs2_n_i,
    input logic       dout_vld_o,
    input logic       burst_active,
    input logic [1:0] burst_cnt
);

    AST_OE_MASKS_VALID: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> !dout_vld_o); // R11

    AST_ZZ_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        zz_i |-> !dout_vld_o); // R12

    AST_ZZ_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        zz_i |=> $stable(burst_cnt)); // R12

    AST_ADV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (burst_active && adsp_n_i && adsc_n_i && adv_n_i && !zz_i) |=> $stable(burst_cnt)); // R5

    AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
        (burst_active && adsp_n_i && adsc_n_i && !adv_n_i && !zz_i)
        |=> (burst_cnt == $past(burst_cnt) + 2'd1)); // R3

    AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (rst)
        (!zz_i && adsp_n_i && !adsc_n_i && !(!cs1_n_i && cs2_i && !cs2_n_i))
        |=> !burst_active); // R10

    AST_PSTROBE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!zz_i && cs1_n_i && !adsp_n_i && adsc_n_i && !burst_active) |=> !burst_active); // R8

endmodule

bind sync_burst_sram sbs_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .zz_i         (zz_i),
    .oe_n_i       (oe_n_i),
    .adsp_n_i     (adsp_n_i),
    .adsc_n_i     (adsc_n_i),
    .adv_n_i      (adv_n_i),
    .cs1_n_i      (cs1_n_i),
    .cs2_i        (cs2_i),
    .cs2_n_i      (cs2_n_i),
    .dout_vld_o   (dout_vld_o),
    .burst_active (burst_active),
    .burst_cnt    (burst_cnt)
);

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;

    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [35:0]   din = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          cs1_n = 1'b0, cs2 = 1'b1, cs2_n = 1'b0;
    logic          gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          oe_n = 1'b0, zz = 1'b0, order = 1'b0;
    logic [35:0]   dout;
    logic          dout_vld;

    int total = 0;
    int bad   = 0;

    // reference state
    logic [35:0]   mem_m [WORDS];
    logic          m_act = 1'b0;
    logic [AW-3:0] m_up = '0;
    logic [1:0]    m_base = '0, m_cnt = '0;
    logic          m_pend = 1'b0, m_vq = 1'b0;
    logic [35:0]   m_pdata = '0, m_dq = '0;

    always #4 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) i_sync_burst_sram (
        .clk(clk), .rst(rst), .addr_i(addr), .din_i(din),
        .adsp_n_i(adsp_n), .adsc_n_i(adsc_n), .adv_n_i(adv_n),
        .cs1_n_i(cs1_n), .cs2_i(cs2), .cs2_n_i(cs2_n),
        .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bw_n_i(bw_n),
        .oe_n_i(oe_n), .zz_i(zz), .order_i(order),
        .dout_o(dout), .dout_vld_o(dout_vld)
    );

    function automatic logic [35:0] pat(input int a, input int s);
        logic [31:0] lo;
        lo = 32'(a) * 32'h0103_0507 + 32'(s) * 32'h1F2E_3D4C + 32'hA5C3_0F1E;
        return {4'(s + a), lo};
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        cs1_n = 1'b0; cs2 = 1'b1; cs2_n = 1'b0;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
        oe_n = 1'b0; zz = 1'b0;
    endtask

    // one clock: update reference from the driven inputs, then compare
    task automatic tick(input string tag);
        logic          sel, p_eff, do_acc, do_wr;
        logic [3:0]    m;
        logic [1:0]    lo;
        logic [AW-1:0] a;
        if (zz) m_vq = 1'b0;
        else begin m_vq = m_pend; m_dq = m_pdata; end
        do_acc = 1'b0; do_wr = 1'b0; a = '0;
        m = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
        if (!zz) begin
            sel   = !cs1_n && cs2 && !cs2_n;
            p_eff = !adsp_n && !cs1_n;
            if (p_eff || !adsc_n) begin
                if (sel) begin
                    m_act = 1'b1; m_up = addr[AW-1:2]; m_base = addr[1:0]; m_cnt = 2'd0;
                    a = addr; do_acc = 1'b1; do_wr = !p_eff && (m != 4'h0);
                end else m_act = 1'b0;
            end else if (m_act) begin
                if (!adv_n) m_cnt = m_cnt + 2'd1;
                lo = order ? (m_base ^ m_cnt) : (m_base + m_cnt);
                a = {m_up, lo}; do_acc = 1'b1; do_wr = (m != 4'h0);
            end
        end
        m_pend = 1'b0;
        if (do_acc) begin
            if (do_wr) begin
                for (int i = 0; i < 4; i++)
                    if (m[i]) mem_m[a][i*9 +: 9] = din[i*9 +: 9];
            end else begin
                m_pend = 1'b1; m_pdata = mem_m[a];
            end
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid"}, {35'd0, dout_vld}, {35'd0, m_vq && !oe_n && !zz});
        if (m_vq && !oe_n && !zz) check({tag, " data"}, dout, m_dq);
    endtask

    task automatic start_c(input int a);
        idle_inputs(); addr = AW'(a); adsc_n = 1'b0;
    endtask

    task automatic flush(input string tag);
        idle_inputs(); tick(tag); tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) mem_m[i] = '0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: quiet after reset, advance alone starts nothing
        check("R1 reset valid", {35'd0, dout_vld}, 36'd0);
        adv_n = 1'b0; tick("R1"); tick("R1");

        // R6: global write of every word, lane strobes set against it
        for (int i = 0; i < WORDS; i++) begin
            start_c(i); gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'(i); din = pat(i, 1);
            tick("R6");
        end
        for (int i = 0; i < WORDS; i++) begin
            start_c(i); tick("R6"); idle_inputs(); tick("R6"); tick("R2");
        end

        // R3/R4: every start offset in both orders
        for (int o = 0; o < 2; o++) begin
            for (int b = 0; b < WORDS; b++) begin
                order = o[0];
                start_c(b); tick("R2");
                idle_inputs(); adv_n = 1'b0;
                for (int s = 0; s < 3; s++) tick(o == 1 ? "R4" : "R3");
                flush(o == 1 ? "R4" : "R3");
            end
        end
        order = 1'b0;

        // R5: advance held high repeats the address
        start_c(13); tick("R5");
        idle_inputs(); adv_n = 1'b0; tick("R5");
        adv_n = 1'b1; tick("R5"); tick("R5");
        adv_n = 1'b0; tick("R5");
        flush("R5");

        // R7: every lane mask on one word, plus non-write cases
        for (int k = 0; k < 16; k++) begin
            start_c(21); gw_n = 1'b0; din = pat(21, 2); tick("R7");
            start_c(21); bwe_n = 1'b0; bw_n = 4'(k); din = pat(k, 3); tick("R7");
            start_c(21); tick("R7"); flush("R7");
        end
        start_c(22); bwe_n = 1'b1; bw_n = 4'h0; din = pat(0, 9); tick("R7");
        start_c(22); tick("R7"); flush("R7");

        // R8: processor strobe with cs1 high does not restart the burst
        start_c(40); tick("R8");
        idle_inputs(); cs1_n = 1'b1; adsp_n = 1'b0; addr = 6'd3; adv_n = 1'b0; tick("R8");
        tick("R8");
        flush("R8");
        idle_inputs(); cs1_n = 1'b1; adsp_n = 1'b0; addr = 6'd5; tick("R8"); tick("R8");

        // R9: both strobes, processor wins as a read; write lands next cycle
        idle_inputs(); adsp_n = 1'b0; adsc_n = 1'b0; addr = 6'd30; gw_n = 1'b0; din = pat(30, 7);
        tick("R9");
        idle_inputs(); gw_n = 1'b0; din = pat(30, 8); tick("R9");
        start_c(30); tick("R9"); flush("R9");

        // R10: deselected strobes end the burst
        start_c(44); tick("R10");
        idle_inputs(); adsc_n = 1'b0; cs2 = 1'b0; tick("R10");
        idle_inputs(); adv_n = 1'b0; tick("R10"); tick("R10"); tick("R10");
        start_c(48); tick("R10");
        idle_inputs(); adsc_n = 1'b0; cs2_n = 1'b1; gw_n = 1'b0; din = pat(48, 5); tick("R10");
        idle_inputs(); adv_n = 1'b0; tick("R10"); tick("R10");
        start_c(52); tick("R10");
        idle_inputs(); adsp_n = 1'b0; cs2 = 1'b0; tick("R10");
        idle_inputs(); adv_n = 1'b0; tick("R10"); tick("R10");
        start_c(48); tick("R10"); flush("R10");

        // R11: output enable masks valid without a clock
        start_c(17); tick("R11");
        idle_inputs(); tick("R11");
        oe_n = 1'b1; #1;
        check("R11 oe high", {35'd0, dout_vld}, 36'd0);
        oe_n = 1'b0; #1;
        check("R11 oe low", {35'd0, dout_vld}, {35'd0, m_vq});
        flush("R11");

        // R12: power-down freezes everything, burst resumes after
        start_c(8); tick("R12");
        idle_inputs(); zz = 1'b1; adv_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0;
        addr = 6'd20; din = pat(20, 11);
        tick("R12"); tick("R12"); tick("R12");
        idle_inputs(); adv_n = 1'b0; tick("R12"); tick("R12");
        flush("R12");
        start_c(20); tick("R12"); flush("R12");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule